// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one DMA channel that moves bytes between system memory and a single peripheral port. It holds two transfer slots, each with its own start address and byte count. While the engine drains one slot, software reloads the other, so a continuous stream never waits on a register write. Software fills slot 0 first and then slot 1, and keeps alternating. The engine flips to the other slot each time a slot runs dry.

A small register file configures and observes the channel. A four-state machine drives it and is visible in a status field. Three interrupt sources feed one interrupt line: stall (no loaded slot is left), next-buffer (the engine has moved on and the emptied slot can be refilled) and peripheral error. The memory side is a request/acknowledge byte port. The peripheral side is a pair of valid/ready byte streams, and a direction input selects which one is used.

To shut the channel down, software first clears the stall and next-buffer enables, then clears the channel enable. The engine finishes the byte in flight, shows STALL for at least one cycle and settles in IDLE.

Top module: `dbuf_pdma`

## Requirements
- R1: After reset the channel state is IDLE (status bits [5:4] = 0), the interrupt status register reads 0, `irq` is low and neither `mem_req` nor `out_valid` is asserted.
- R2: Register offsets are control 0x00, interrupt status 0x04, port select 0x08, status 0x0C, count0 0x20, base0 0x24, count1 0x30, base1 0x34. The control register keeps only bits 0 (stall irq enable), 1 (next-buffer irq enable), 3 (error irq enable), 4 (channel enable) and 6 (ignore peripheral error), and the other bits read 0. The port select register keeps its low 4 bits and drives `port_sel`.
- R3: Writing a nonzero value to a count register loads that slot. Writing zero leaves it unloaded. With enable set and the active slot loaded, an IDLE or STALL channel enters ON (state 2).
- R4: When `dir` is 1, bytes are read from memory at ascending addresses starting at the slot base and leave on the output stream in order. Reading back a slot gives its base advanced by one and its count reduced by one for each byte moved.
- R5: When `dir` is 0, bytes accepted on the input stream are written to memory at ascending addresses starting at the slot base.
- R6: If a slot empties while the other slot is loaded, the channel enters NEXT (state 3) and the active slot index (status bit 0) toggles. Refilling the emptied slot returns the channel to ON.
- R7: If a slot empties while the other slot is unloaded, the channel enters STALL (state 1) and the active slot index still toggles.
- R8: Once enable is cleared in ON or NEXT, the byte in flight completes, the channel passes through STALL and then reaches IDLE, and no further bytes move.
- R9: Interrupt status bit 0 is set while in STALL and bit 1 while in NEXT. Bit 3 latches a `per_err` pulse unless control bit 6 is set. Any write to the interrupt status register clears bit 3.
- R10: `irq` is high exactly when some interrupt status bit and its matching control enable bit (0, 1 or 3) are both set.
- R11: A memory request, once raised, stays raised with a stable address until it is acknowledged, and an output byte stays valid and stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| dir | input | 1 | 1 = memory to peripheral, 0 = peripheral to memory |
| port_sel | output | PW | Selected peripheral port |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory access acknowledge |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ack` |
| out_valid | output | 1 | Output stream byte valid |
| out_data | output | 8 | Output stream byte |
| out_ready | input | 1 | Output stream ready |
| in_valid | input | 1 | Input stream byte valid |
| in_data | input | 8 | Input stream byte |
| in_ready | output | 1 | Input stream ready |
| per_err | input | 1 | Peripheral error pulse |
| irq | output | 1 | Channel interrupt |

## Verification
The bench builds the block with its defaults: 32-bit addresses, a 16-bit count and a 4-bit port select. The full address range can be read back, so base advance and slot contents are checked word for word. Short counts of two to forty bytes bring slot exhaustion, slot alternation, refill during NEXT, a zero-count write and a disable issued mid-transfer into reach within a few hundred cycles. Both stream directions and all three interrupt sources are exercised against a memory model whose contents are derived from the address.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_STALL = 2'd1,
    CH_ON    = 2'd2,
    CH_NEXT  = 2'd3
  } ch_state_t;

  localparam logic [5:0] OFS_CTRL  = 6'h00;
  localparam logic [5:0] OFS_INT   = 6'h04;
  localparam logic [5:0] OFS_PORT  = 6'h08;
  localparam logic [5:0] OFS_STAT  = 6'h0C;
  localparam logic [5:0] OFS_CNT0  = 6'h20;
  localparam logic [5:0] OFS_BASE0 = 6'h24;
  localparam logic [5:0] OFS_CNT1  = 6'h30;
  localparam logic [5:0] OFS_BASE1 = 6'h34;

  localparam int B_STALL_EN = 0;
  localparam int B_NFB_EN   = 1;
  localparam int B_ERR_EN   = 3;
  localparam int B_ENABLE   = 4;
  localparam int B_IGN_ERR  = 6;
  localparam logic [6:0] CTRL_MASK = 7'b101_1011;

  // interrupt line: any flag whose enable is set
  function automatic logic irq_merge(input logic [3:0] flags, input logic [3:0] ens);
    return |(flags & ens);
  endfunction
endpackage

// File: rtl/pdma_slot.sv
`timescale 1ns/1ps
module pdma_slot #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cnt,
  input  logic          wr_base,
  input  logic [CW-1:0] cnt_in,
  input  logic [AW-1:0] base_in,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] remain,
  output logic          loaded,
  output logic          last_step
);
  function automatic logic [AW-1:0] bump_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction
  function automatic logic [CW-1:0] drop_cnt(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  assign last_step = step && (remain == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      remain <= '0;
      loaded <= 1'b0;
    end else begin
      if (wr_base)   addr <= base_in;
      else if (step) addr <= bump_addr(addr);
      if (wr_cnt) begin
        remain <= cnt_in;
        loaded <= (cnt_in != '0);
      end else if (step) begin
        remain <= drop_cnt(remain);
        if (last_step) loaded <= 1'b0;
      end
    end
  end

  a_r3_zero_count_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && cnt_in == '0) |=> !loaded);
  a_r4_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_base) |=> addr == $past(addr) + AW'(1));
endmodule

// File: rtl/pdma_mover.sv
`timescale 1ns/1ps
module pdma_mover #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          dir,
  input  logic [AW-1:0] src_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          byte_done,
  output logic          busy
);
  typedef enum logic [1:0] {PH_IDLE, PH_MEM, PH_PER} ph_t;
  ph_t        ph;
  logic       to_per;
  logic [7:0] hold;

  assign in_ready  = (ph == PH_IDLE) && go && !dir;
  assign mem_req   = (ph == PH_MEM);
  assign mem_we    = !to_per;
  assign mem_addr  = src_addr;
  assign mem_wdata = hold;
  assign out_valid = (ph == PH_PER);
  assign out_data  = hold;
  assign busy      = (ph != PH_IDLE);
  assign byte_done = ((ph == PH_MEM) && mem_ack && !to_per) ||
                     ((ph == PH_PER) && out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      to_per <= 1'b0;
      hold   <= '0;
    end else begin
      case (ph)
        PH_IDLE:
          if (go && dir) begin
            to_per <= 1'b1;
            ph     <= PH_MEM;
          end else if (in_ready && in_valid) begin
            to_per <= 1'b0;
            hold   <= in_data;
            ph     <= PH_MEM;
          end
        PH_MEM:
          if (mem_ack) begin
            if (to_per) begin
              hold <= mem_rdata;
              ph   <= PH_PER;
            end else begin
              ph <= PH_IDLE;
            end
          end
        PH_PER:  if (out_ready) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  a_r11_out_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/pdma_chan_fsm.sv
`timescale 1ns/1ps
module pdma_chan_fsm
  import pdma_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      loaded_cur,
  input  logic      loaded_oth,
  input  logic      last_done,
  input  logic      busy,
  output ch_state_t state,
  output logic      cur
);
  ch_state_t nxt;
  logic      flip;

  always_comb begin
    nxt  = state;
    flip = 1'b0;
    case (state)
      CH_IDLE:  if (enable && loaded_cur) nxt = CH_ON;
      CH_ON, CH_NEXT: begin
        if (last_done) begin
          flip = 1'b1;
          nxt  = loaded_oth ? CH_NEXT : CH_STALL;
        end else if (!enable && !busy) begin
          nxt = CH_STALL;
        end else if (state == CH_NEXT && loaded_oth) begin
          nxt = CH_ON;
        end
      end
      CH_STALL: begin
        if (!enable)         nxt = CH_IDLE;
        else if (loaded_cur) nxt = CH_ON;
      end
      default: nxt = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CH_IDLE;
      cur   <= 1'b0;
    end else begin
      state <= nxt;
      if (flip) cur <= !cur;
    end
  end

  a_r8_stall_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CH_ON || state == CH_NEXT) |=> state != CH_IDLE);
  a_r7_slot_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> cur != $past(cur));
  a_r6_enter_next: assert property (@(posedge clk) disable iff (!rst_n)
    (last_done && loaded_oth) |=> state == CH_NEXT);
  a_r7_enter_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (last_done && !loaded_oth) |=> state == CH_STALL);
endmodule

// File: rtl/dbuf_pdma.sv
`timescale 1ns/1ps
module dbuf_pdma
  import pdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          dir,
  output logic [PW-1:0] port_sel,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  input  logic          per_err,
  output logic          irq
);
  localparam int NSLOT = 2;

  logic [6:0]    ctrl_q;
  logic [PW-1:0] port_q;
  logic          err_q;
  ch_state_t     state;
  logic          cur, go, busy, byte_done, last_done;
  logic          wr_int;
  logic [AW-1:0] s_addr   [NSLOT];
  logic [CW-1:0] s_remain [NSLOT];
  logic [NSLOT-1:0] s_loaded, s_last;
  logic [3:0]    int_flags, int_ens;

  assign wr_int = reg_we && (reg_addr == OFS_INT);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [5:0] CNT_OFS  = (i == 0) ? OFS_CNT0  : OFS_CNT1;
    localparam logic [5:0] BASE_OFS = (i == 0) ? OFS_BASE0 : OFS_BASE1;
    pdma_slot #(.AW(AW), .CW(CW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_cnt    (reg_we && (reg_addr == CNT_OFS)),
      .wr_base   (reg_we && (reg_addr == BASE_OFS)),
      .cnt_in    (reg_wdata[CW-1:0]),
      .base_in   (reg_wdata[AW-1:0]),
      .step      (byte_done && (cur == 1'(i))),
      .addr      (s_addr[i]),
      .remain    (s_remain[i]),
      .loaded    (s_loaded[i]),
      .last_step (s_last[i])
    );
  end

  assign last_done = |s_last;
  assign go = ctrl_q[B_ENABLE] && (state == CH_ON || state == CH_NEXT) && s_loaded[cur];

  pdma_chan_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (ctrl_q[B_ENABLE]),
    .loaded_cur (s_loaded[cur]),
    .loaded_oth (s_loaded[!cur]),
    .last_done  (last_done),
    .busy       (busy),
    .state      (state),
    .cur        (cur)
  );

  pdma_mover #(.AW(AW)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .dir       (dir),
    .src_addr  (s_addr[cur]),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .byte_done (byte_done),
    .busy      (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      port_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (reg_we && reg_addr == OFS_CTRL) ctrl_q <= reg_wdata[6:0] & CTRL_MASK;
      if (reg_we && reg_addr == OFS_PORT) port_q <= reg_wdata[PW-1:0];
      if (per_err && !ctrl_q[B_IGN_ERR]) err_q <= 1'b1;
      else if (wr_int)                   err_q <= 1'b0;
    end
  end

  assign int_flags = {err_q, 1'b0, state == CH_NEXT, state == CH_STALL};
  assign int_ens   = {ctrl_q[B_ERR_EN], 1'b0, ctrl_q[B_NFB_EN], ctrl_q[B_STALL_EN]};
  assign irq       = irq_merge(int_flags, int_ens);
  assign port_sel  = port_q;

  always_comb begin
    case (reg_addr)
      OFS_CTRL:  reg_rdata = 32'(ctrl_q);
      OFS_INT:   reg_rdata = 32'(int_flags);
      OFS_PORT:  reg_rdata = 32'(port_q);
      OFS_STAT:  reg_rdata = 32'({state, 3'b000, cur});
      OFS_CNT0:  reg_rdata = 32'(s_remain[0]);
      OFS_BASE0: reg_rdata = 32'(s_addr[0]);
      OFS_CNT1:  reg_rdata = 32'(s_remain[1]);
      OFS_BASE1: reg_rdata = 32'(s_addr[1]);
      default:   reg_rdata = '0;
    endcase
  end

  a_r9_err_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int && !per_err) |=> !err_q);
  a_r9_err_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_IGN_ERR] && !err_q && !(reg_we && reg_addr == OFS_CTRL)) |=> !err_q);
  a_r10_stall_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CH_STALL && ctrl_q[B_STALL_EN]) |-> irq);
  a_r10_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[3:0] == 4'b0000) |-> !irq);
endmodule

// File: tb/tb_dbuf_pdma.sv
`timescale 1ns/1ps
module tb_dbuf_pdma;
  localparam int AW = 32, CW = 16, PW = 4;
  localparam logic [5:0] A_CTRL = 6'h00, A_INT = 6'h04, A_PORT = 6'h08, A_STAT = 6'h0C;
  localparam logic [5:0] A_CNT0 = 6'h20, A_BASE0 = 6'h24, A_CNT1 = 6'h30, A_BASE1 = 6'h34;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic dir = 1'b1;
  logic [PW-1:0] port_sel;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = '0;
  logic out_valid, out_ready = 1'b0;
  logic [7:0] out_data;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic per_err = 1'b0, irq;

  dbuf_pdma #(.AW(AW), .CW(CW), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dir(dir), .port_sel(port_sel),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .per_err(per_err), .irq(irq)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0]  exp_out [$];
  logic [39:0] exp_wr  [$];
  logic [7:0]  src_q   [$];
  bit hold_out = 1'b0;
  bit in_hs = 1'b0;
  logic [7:0]  e8;
  logic [39:0] e40;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor and responders, all away from the rising edge
  always @(negedge clk) begin
    out_ready = !hold_out;
    if (rst_n && out_valid && out_ready) begin
      if (exp_out.size() == 0) chk(1'b0, "R4", "unexpected output byte", 32'(out_data), 0);
      else begin
        e8 = exp_out.pop_front();
        chk(out_data == e8, "R4", "output byte", 32'(out_data), 32'(e8));
      end
    end
    if (rst_n && mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        if (exp_wr.size() == 0) chk(1'b0, "R5", "unexpected memory write", mem_addr, 0);
        else begin
          e40 = exp_wr.pop_front();
          chk({mem_addr, mem_wdata} == e40, "R5", "memory write addr/data",
              {mem_addr[23:0], mem_wdata}, e40[31:0]);
        end
      end else mem_rdata = pat(mem_addr);
    end else mem_ack = 1'b0;
    if (in_hs) void'(src_q.pop_front());
    in_valid = (src_q.size() > 0);
    in_data  = in_valid ? src_q[0] : 8'h00;
    in_hs    = in_valid && in_ready;
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req, input string what);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, what, d, exp);
  endtask

  task automatic wait_state(input logic [1:0] s, input string req, input int limit);
    logic [31:0] d = '0;
    bit hit = 1'b0;
    for (int k = 0; k < limit && !hit; k++) begin
      rd(A_STAT, d);
      if (d[5:4] == s) hit = 1'b1;
    end
    chk(hit, req, "channel state reached", 32'(d[5:4]), 32'(s));
  endtask

  task automatic load_tx(input bit slot, input logic [31:0] base, input int n);
    for (int k = 0; k < n; k++) exp_out.push_back(pat(base + 32'(k)));
    wr(slot ? A_BASE1 : A_BASE0, base);
    wr(slot ? A_CNT1 : A_CNT0, 32'(n));
  endtask

  task automatic pulse_err();
    @(negedge clk); per_err = 1'b1;
    @(negedge clk); per_err = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] d, r1, r2;
    bit saw_stall, reached_idle;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(A_STAT, 32'h0, "R1", "status after reset");
    rd_chk(A_INT, 32'h0, "R1", "interrupt status after reset");
    chk(!irq && !mem_req && !out_valid, "R1", "outputs quiet after reset",
        {29'd0, irq, mem_req, out_valid}, 0);

    // R2 register map and masking
    wr(A_PORT, 32'h3A);
    rd_chk(A_PORT, 32'hA, "R2", "port select keeps low 4 bits");
    chk(port_sel == 4'hA, "R2", "port_sel output", 32'(port_sel), 32'hA);
    wr(A_CTRL, 32'hAF);
    rd_chk(A_CTRL, 32'h0B, "R2", "control keeps defined bits only");
    wr(A_CTRL, 32'h0);

    // memory to peripheral, slot alternation
    dir = 1'b1;
    load_tx(1'b0, 32'h100, 4);
    load_tx(1'b1, 32'h200, 3);
    rd_chk(A_CNT0, 32'd4, "R3", "count0 loaded");
    rd_chk(A_BASE1, 32'h200, "R2", "base1 readback");
    wr(A_CTRL, 32'h13);
    wait_state(2'd3, "R6", 200);
    hold_out = 1'b1;
    rd_chk(A_CNT0, 32'd0, "R4", "slot0 drained");
    rd_chk(A_STAT, 32'h31, "R6", "NEXT with slot1 active");
    rd_chk(A_INT, 32'h2, "R9", "next-buffer flag in NEXT");
    chk(irq, "R10", "irq from next-buffer", 32'(irq), 1);
    load_tx(1'b0, 32'h300, 2);
    rd_chk(A_STAT, 32'h21, "R6", "refill returns to ON");
    hold_out = 1'b0;
    wait_state(2'd1, "R7", 500);
    chk(exp_out.size() == 0, "R4", "all output bytes seen", 32'(exp_out.size()), 0);
    rd_chk(A_INT, 32'h1, "R9", "stall flag in STALL");
    chk(irq, "R10", "irq from stall", 32'(irq), 1);
    rd_chk(A_BASE1, 32'h203, "R4", "base1 advanced");
    rd_chk(A_CNT1, 32'd0, "R4", "count1 drained");
    rd_chk(A_STAT, 32'h11, "R7", "STALL with slot index toggled");

    // R3 zero count, R10 masking, R7 resume from stall
    wr(A_CNT1, 32'd0);
    rd_chk(A_STAT, 32'h11, "R3", "zero count does not start");
    wr(A_CTRL, 32'h10);
    @(negedge clk);
    chk(!irq, "R10", "stall masked", 32'(irq), 0);
    load_tx(1'b1, 32'h600, 2);
    rd_chk(A_STAT, 32'h21, "R3", "loaded slot leaves STALL to ON");
    wait_state(2'd1, "R7", 200);
    chk(exp_out.size() == 0, "R4", "resumed bytes seen", 32'(exp_out.size()), 0);
    rd_chk(A_STAT, 32'h10, "R7", "STALL on slot0 after slot1");

    // R8 disable mid-transfer
    load_tx(1'b0, 32'h700, 40);
    d = 32'd40;
    for (int k = 0; k < 500 && d > 32'd30; k++) rd(A_CNT0, d);
    wr(A_CTRL, 32'h0);
    saw_stall = 1'b0; reached_idle = 1'b0;
    for (int k = 0; k < 50 && !reached_idle; k++) begin
      rd(A_STAT, d);
      if (d[5:4] == 2'd1) saw_stall = 1'b1;
      if (d[5:4] == 2'd0) reached_idle = 1'b1;
    end
    chk(saw_stall && reached_idle, "R8", "STALL then IDLE", {30'd0, saw_stall, reached_idle}, 3);
    rd(A_CNT0, r1);
    repeat (10) @(negedge clk);
    rd(A_CNT0, r2);
    chk(r1 == r2 && r1 != 0, "R8", "no bytes move after disable", r2, r1);
    chk(exp_out.size() == int'(r1), "R8", "bytes out match count moved", 32'(exp_out.size()), r1);
    exp_out.delete();
    wr(A_CNT0, 32'd0);

    // R5 peripheral to memory across both slots
    dir = 1'b0;
    wr(A_BASE0, 32'h800); wr(A_CNT0, 32'd3);
    wr(A_BASE1, 32'h900); wr(A_CNT1, 32'd2);
    exp_wr.push_back({32'h800, 8'hA1});
    exp_wr.push_back({32'h801, 8'hA2});
    exp_wr.push_back({32'h802, 8'hA3});
    exp_wr.push_back({32'h900, 8'hA4});
    exp_wr.push_back({32'h901, 8'hA5});
    wr(A_CTRL, 32'h12);
    src_q.push_back(8'hA1); src_q.push_back(8'hA2); src_q.push_back(8'hA3);
    src_q.push_back(8'hA4); src_q.push_back(8'hA5);
    wait_state(2'd1, "R5", 300);
    chk(exp_wr.size() == 0, "R5", "all memory writes seen", 32'(exp_wr.size()), 0);
    chk(src_q.size() == 0, "R5", "input stream drained", 32'(src_q.size()), 0);
    rd_chk(A_BASE1, 32'h902, "R5", "base1 advanced");
    chk(!irq, "R10", "stall without enable keeps irq low", 32'(irq), 0);

    // R9 / R10 error handling
    wr(A_CTRL, 32'h18);
    pulse_err();
    rd_chk(A_INT, 32'h9, "R9", "error latched");
    chk(irq, "R10", "irq from error", 32'(irq), 1);
    wr(A_INT, 32'h0);
    rd_chk(A_INT, 32'h1, "R9", "write clears error");
    chk(!irq, "R10", "irq drops after clear", 32'(irq), 0);
    wr(A_CTRL, 32'h48);
    pulse_err();
    rd_chk(A_INT, 32'h0, "R9", "error ignored when bit6 set");
    wr(A_CTRL, 32'h00);
    pulse_err();
    rd_chk(A_INT, 32'h8, "R9", "error latched with irq disabled");
    chk(!irq, "R10", "error masked", 32'(irq), 0);
    wr(A_INT, 32'h0);
    rd_chk(A_INT, 32'h0, "R9", "error cleared again");

    finish_run();
  end
endmodule